// File: doc/BRIEF.md
# Transform-to-Synthesis Reorder Buffer

This block sits on a point-to-point link between an inverse block transform and a 32-subband synthesis filter bank. Per granule the transform produces one input packet for each subband, and each packet carries 18 time samples. The filter bank needs the transpose: one packet per time slot, each packet holding that slot's sample from all 32 subbands. The buffer stores a full granule, then reads it back column by column. The result is an 18-by-32 corner turn.

Each side uses a valid/ready handshake, and one packet moves on each accepted transfer. The buffer has two banks, so one granule can fill while the previous granule drains. A channel tag arrives alongside the input packets. It is captured on the first packet of a granule and is shown with every output packet of that granule. The other per-granule decoding fields (a 5-bit band limit, a 2-bit window kind and a 1-bit mixed-window flag) are accepted on the input side and dropped, because the synthesis stage has no use for them.

Top module: `rb_reorder_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The k-th input packet accepted for a granule holds subband k, for k from 0 to 31. Its time sample j sits at bits `[j*SAMP_W +: SAMP_W]` of `in_samples`.
- R3: An output packet carries the index of its time slot t on `out_slot`. Lane s, at bits `[s*SAMP_W +: SAMP_W]` of `out_samples`, holds time sample t of subband s of the same granule.
- R4: `out_valid` for a granule first rises on the cycle after the handshake of that granule's 32nd input packet. It stays low while no granule is complete and undrained.
- R5: The packets of a granule leave in slot order 0 to 17. The bank is released after the handshake of slot 17.
- R6: `out_chan` equals the `in_chan` value sampled with subband 0 of the granule, for all 18 output packets. Values on `in_chan` during later packets of that granule have no effect.
- R7: `in_band_lim`, `in_win_kind` and `in_mixed_win` have no effect on any output.
- R8: While one granule waits in one bank or is being read from it, the buffer accepts the next granule into the other bank. `in_ready` is 0 exactly when both banks hold complete, undrained granules.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_samples`, `out_chan` and `out_slot` stay unchanged.
- R10: Granules leave in the same order in which they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Buffer can take an input packet |
| in_samples | input | NUM_SLOT*SAMP_W (288) | The 18 time samples of one subband |
| in_chan | input | CHAN_W (1) | Channel tag, used on subband 0 only |
| in_band_lim | input | 5 | Band-limit field, dropped |
| in_win_kind | input | 2 | Window-kind field, dropped |
| in_mixed_win | input | 1 | Mixed-window flag, dropped |
| out_valid | output | 1 | Output packet present |
| out_ready | input | 1 | Filter bank takes the output packet |
| out_samples | output | NUM_SB*SAMP_W (512) | One time slot across all 32 subbands |
| out_chan | output | CHAN_W (1) | Channel tag of the granule being read |
| out_slot | output | SLOT_W (5) | Time-slot index of the output packet |

## Verification
The bench builds the block with its default sizes: 32 subbands, 18 slots, 16-bit samples and a 1-bit channel tag. This makes the real wrap points reachable: subband 31 into 0, slot 17 into 0, and the bank toggle. Because the sample width is wide, a hashed sample value shows any swap of lanes, slots or granules.

An opening window with `out_ready` held low fills both banks and holds the input stall. A later back-to-back phase then runs filling and draining in the same cycles. Random gaps in between exercise output hold under backpressure, tag changes on non-first packets, and random values on the dropped fields.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int unsigned RB_SUBBANDS = 32;
    localparam int unsigned RB_SLOTS    = 18;
    localparam int unsigned RB_SAMP_W   = 16;
    localparam int unsigned RB_CHAN_W   = 1;
    localparam int unsigned RB_BANKS    = 2;
    localparam int unsigned RB_BANK_W   = $clog2(RB_BANKS);
    localparam int unsigned RB_LIM_W    = 5;
    localparam int unsigned RB_WIN_W    = 2;
endpackage

// File: rtl/rb_wr_seq.sv
module rb_wr_seq
    import rb_pkg::*;
#(
    parameter  int unsigned NUM_SB = RB_SUBBANDS,
    localparam int unsigned SB_W   = $clog2(NUM_SB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [RB_BANKS-1:0]  bank_full,
    output logic                 in_ready,
    output logic                 in_fire,
    output logic [RB_BANK_W-1:0] wr_bank,
    output logic [SB_W-1:0]      wr_sb,
    output logic                 fill_vld
);
    typedef struct packed {
        logic [RB_BANK_W-1:0] bank;
        logic [SB_W-1:0]      sb;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      last_sb;

    always_comb begin
        st_d     = st_q;
        last_sb  = (st_q.sb == SB_W'(NUM_SB - 1));
        in_ready = ~bank_full[st_q.bank];
        in_fire  = in_valid & in_ready;
        fill_vld = in_fire & last_sb;
        if (in_fire) begin
            if (last_sb) begin
                st_d.sb   = '0;
                st_d.bank = st_q.bank + 1'b1;
            end else begin
                st_d.sb = st_q.sb + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_bank = st_q.bank;
    assign wr_sb   = st_q.sb;

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (&bank_full) |-> !in_ready); // R8
endmodule

// File: rtl/rb_rd_seq.sv
module rb_rd_seq
    import rb_pkg::*;
#(
    parameter  int unsigned NUM_SLOT = RB_SLOTS,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 out_fire,
    output logic [RB_BANK_W-1:0] rd_bank,
    output logic [SLOT_W-1:0]    rd_slot,
    output logic                 drain_vld
);
    typedef struct packed {
        logic [RB_BANK_W-1:0] bank;
        logic [SLOT_W-1:0]    slot;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      last_slot;

    always_comb begin
        st_d      = st_q;
        last_slot = (st_q.slot == SLOT_W'(NUM_SLOT - 1));
        drain_vld = out_fire & last_slot;
        if (out_fire) begin
            if (last_slot) begin
                st_d.slot = '0;
                st_d.bank = st_q.bank + 1'b1;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_bank = st_q.bank;
    assign rd_slot = st_q.slot;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_slot <= SLOT_W'(NUM_SLOT - 1)); // R5
endmodule

// File: rtl/rb_occupancy.sv
module rb_occupancy
    import rb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_vld,
    input  logic [RB_BANK_W-1:0] set_bank,
    input  logic                 clr_vld,
    input  logic [RB_BANK_W-1:0] clr_bank,
    output logic [RB_BANKS-1:0]  full
);
    logic [RB_BANKS-1:0] full_d, full_q;

    always_comb begin
        full_d = full_q;
        for (int b = 0; b < RB_BANKS; b++) begin
            if (set_vld && set_bank == RB_BANK_W'(b)) full_d[b] = 1'b1;
            if (clr_vld && clr_bank == RB_BANK_W'(b)) full_d[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) full_q <= '0;
        else        full_q <= full_d;
    end

    assign full = full_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |-> !full_q[set_bank]); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vld |-> full_q[clr_bank]); // R5
endmodule

// File: rtl/rb_bank_store.sv
module rb_bank_store
    import rb_pkg::*;
#(
    parameter  int unsigned NUM_SB   = RB_SUBBANDS,
    parameter  int unsigned NUM_SLOT = RB_SLOTS,
    parameter  int unsigned SAMP_W   = RB_SAMP_W,
    parameter  int unsigned CHAN_W   = RB_CHAN_W,
    localparam int unsigned SB_W     = $clog2(NUM_SB),
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SB_W-1:0]            wr_sb,
    input  logic [NUM_SLOT*SAMP_W-1:0] wr_row,
    input  logic [CHAN_W-1:0]          wr_chan,
    input  logic [SLOT_W-1:0]          rd_slot,
    output logic [NUM_SB*SAMP_W-1:0]   rd_col,
    output logic [CHAN_W-1:0]          rd_chan
);
    // Sample storage carries no reset: a row is always written before it is read.
    logic [SAMP_W-1:0] mem_q [NUM_SB][NUM_SLOT];
    logic [CHAN_W-1:0] chan_d, chan_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int j = 0; j < NUM_SLOT; j++) begin
                mem_q[wr_sb][j] <= wr_row[j*SAMP_W +: SAMP_W];
            end
        end
    end

    always_comb begin
        chan_d = chan_q;
        if (wr_en && wr_sb == '0) chan_d = wr_chan;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    always_comb begin
        for (int s = 0; s < NUM_SB; s++) begin
            rd_col[s*SAMP_W +: SAMP_W] = mem_q[s][rd_slot];
        end
    end

    assign rd_chan = chan_q;
endmodule

// File: rtl/rb_reorder_top.sv
module rb_reorder_top
    import rb_pkg::*;
#(
    parameter  int unsigned NUM_SB   = RB_SUBBANDS,
    parameter  int unsigned NUM_SLOT = RB_SLOTS,
    parameter  int unsigned SAMP_W   = RB_SAMP_W,
    parameter  int unsigned CHAN_W   = RB_CHAN_W,
    localparam int unsigned SB_W     = $clog2(NUM_SB),
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOT),
    localparam int unsigned ROW_W    = NUM_SLOT * SAMP_W,
    localparam int unsigned COL_W    = NUM_SB * SAMP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ROW_W-1:0]    in_samples,
    input  logic [CHAN_W-1:0]   in_chan,
    input  logic [RB_LIM_W-1:0] in_band_lim,
    input  logic [RB_WIN_W-1:0] in_win_kind,
    input  logic                in_mixed_win,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [COL_W-1:0]    out_samples,
    output logic [CHAN_W-1:0]   out_chan,
    output logic [SLOT_W-1:0]   out_slot
);
    logic                 in_fire, fill_vld, drain_vld, out_fire;
    logic [RB_BANK_W-1:0] wr_bank, rd_bank;
    logic [SB_W-1:0]      wr_sb;
    logic [SLOT_W-1:0]    rd_slot;
    logic [RB_BANKS-1:0]  bank_full;
    logic [COL_W-1:0]     bank_col  [RB_BANKS];
    logic [CHAN_W-1:0]    bank_chan [RB_BANKS];

    // The synthesis side needs none of these fields; they end here.
    logic side_unused;
    assign side_unused = ^{in_band_lim, in_win_kind, in_mixed_win};

    rb_wr_seq #(.NUM_SB(NUM_SB)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bank_full(bank_full),
        .in_ready(in_ready), .in_fire(in_fire), .wr_bank(wr_bank),
        .wr_sb(wr_sb), .fill_vld(fill_vld)
    );

    rb_rd_seq #(.NUM_SLOT(NUM_SLOT)) u_rd (
        .clk(clk), .rst_n(rst_n), .out_fire(out_fire), .rd_bank(rd_bank),
        .rd_slot(rd_slot), .drain_vld(drain_vld)
    );

    rb_occupancy u_occ (
        .clk(clk), .rst_n(rst_n), .set_vld(fill_vld), .set_bank(wr_bank),
        .clr_vld(drain_vld), .clr_bank(rd_bank), .full(bank_full)
    );

    for (genvar b = 0; b < RB_BANKS; b++) begin : g_bank
        rb_bank_store #(
            .NUM_SB(NUM_SB), .NUM_SLOT(NUM_SLOT), .SAMP_W(SAMP_W), .CHAN_W(CHAN_W)
        ) u_store (
            .clk(clk), .rst_n(rst_n),
            .wr_en(in_fire && wr_bank == RB_BANK_W'(b)),
            .wr_sb(wr_sb), .wr_row(in_samples), .wr_chan(in_chan),
            .rd_slot(rd_slot), .rd_col(bank_col[b]), .rd_chan(bank_chan[b])
        );
    end

    assign out_valid   = bank_full[rd_bank];
    assign out_fire    = out_valid & out_ready;
    assign out_samples = bank_col[rd_bank];
    assign out_chan    = bank_chan[rd_bank];
    assign out_slot    = rd_slot;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_samples)
                                       && $stable(out_chan) && $stable(out_slot))); // R9
    AST_TAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_slot != SLOT_W'(NUM_SLOT - 1)) |=> $stable(out_chan)); // R6
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_slot != SLOT_W'(NUM_SLOT - 1)) |=> (out_slot == $past(out_slot) + 1'b1)); // R5
endmodule

// File: tb/tb_rb_reorder_top.sv
`timescale 1ns/1ps
module tb_rb_reorder_top;
    localparam int NSB   = 32;
    localparam int NSL   = 18;
    localparam int SW    = 16;
    localparam int NG    = 16;
    localparam int WDOG  = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [NSL*SW-1:0] in_samples = '0;
    logic [0:0] in_chan = '0;
    logic [4:0] in_band_lim = '0;
    logic [1:0] in_win_kind = '0;
    logic in_mixed_win = 1'b0;
    logic out_valid, out_ready = 1'b0;
    logic [NSB*SW-1:0] out_samples;
    logic [0:0] out_chan;
    logic [4:0] out_slot;

    always #4 clk = ~clk;

    rb_reorder_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_samples(in_samples), .in_chan(in_chan), .in_band_lim(in_band_lim),
        .in_win_kind(in_win_kind), .in_mixed_win(in_mixed_win),
        .out_valid(out_valid), .out_ready(out_ready), .out_samples(out_samples),
        .out_chan(out_chan), .out_slot(out_slot)
    );

    int unsigned salt;
    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic logic [SW-1:0] samp(int g, int sb, int t);
        int unsigned h;
        h = salt ^ (g * 32'h9E37) ^ (sb * 32'h85EB) ^ (t * 32'hC2B3);
        h = h * 32'h2545F491;
        h = h ^ (h >> 15);
        return SW'(h);
    endfunction

    function automatic logic chan_of(int g);
        int unsigned h;
        h = (g * 32'h27D4EB2D) ^ salt;
        return h[7];
    endfunction

    function automatic logic [NSL*SW-1:0] row_of(int g, int sb);
        logic [NSL*SW-1:0] r;
        for (int t = 0; t < NSL; t++) r[t*SW +: SW] = samp(g, sb, t);
        return r;
    endfunction

    function automatic logic [NSB*SW-1:0] col_of(int g, int t);
        logic [NSB*SW-1:0] c;
        for (int s = 0; s < NSB; s++) c[s*SW +: SW] = samp(g, s, t);
        return c;
    endfunction

    initial begin
        int in_g, in_sb, out_g, out_t, cyc;
        bit pend_in, pend_out;
        int p_in, p_out;
        logic [NSB*SW-1:0] exp_col;
        salt = $urandom(32'd20250);
        in_g = 0; in_sb = 0; out_g = 0; out_t = 0; cyc = 0;
        pend_in = 0; pend_out = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", $sformatf("out_valid=%0b exp 0", out_valid));
        check(in_ready == 1'b1, "R1", $sformatf("in_ready=%0b exp 1", in_ready));

        while (out_g < NG) begin
            if (cyc >= WDOG) begin
                check(1'b0, "watchdog", $sformatf("out_g=%0d exp %0d", out_g, NG));
                break;
            end
            if (pend_in) begin
                if (in_sb == NSB - 1) begin in_sb = 0; in_g++; end
                else in_sb++;
            end
            if (pend_out) begin
                if (out_t == NSL - 1) begin out_t = 0; out_g++; end
                else out_t++;
            end
            if (out_g >= NG) break;

            // R4 R8: exact valid and ready from the count of complete granules
            check(out_valid == (in_g != out_g), "R4",
                  $sformatf("out_valid=%0b exp %0b", out_valid, in_g != out_g));
            check(in_ready == ((in_g - out_g) < 2), "R8",
                  $sformatf("in_ready=%0b exp %0b", in_ready, (in_g - out_g) < 2));
            if (out_valid) begin
                exp_col = col_of(out_g, out_t);
                // R2 R3 R10: lane mapping of the corner turn, granule order; R7 side fields random
                check(out_samples == exp_col, "R3",
                      $sformatf("g%0d t%0d out=%h exp %h", out_g, out_t, out_samples, exp_col));
                check(out_slot == 5'(out_t), "R5",
                      $sformatf("out_slot=%0d exp %0d", out_slot, out_t));
                check(out_chan == chan_of(out_g), "R6",
                      $sformatf("out_chan=%0b exp %0b", out_chan, chan_of(out_g)));
            end

            if (cyc < 150) begin p_in = 100; p_out = 0; end
            else if (out_g >= NG - 4) begin p_in = 100; p_out = 100; end
            else begin p_in = 60; p_out = 65; end

            in_valid = (in_g < NG) && (($urandom % 100) < p_in);
            in_samples = row_of(in_g, in_sb);
            in_chan = (in_sb == 0) ? chan_of(in_g) : 1'($urandom);
            in_band_lim = 5'($urandom);
            in_win_kind = 2'($urandom);
            in_mixed_win = 1'($urandom);
            out_ready = (($urandom % 100) < p_out);
            pend_in = in_valid && in_ready;
            pend_out = out_valid && out_ready;
            cyc++;
            @(negedge clk);
        end

        in_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R5", $sformatf("after drain out_valid=%0b exp 0", out_valid));
        check(in_ready == 1'b1, "R8", $sformatf("after drain in_ready=%0b exp 1", in_ready));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule